// File: doc/BRIEF.md
# Accumulator ALU Execute Unit

This block is the execute stage of a small 8-bit accumulator machine whose register file holds 128 bytes. Each cycle it accepts one 14-bit instruction word together with the current working register W, the byte read from the addressed file register and the incoming carry. It decodes the word and computes the result. It then reports, one clock later, the value to be written and where it goes: W, the file register, or neither. Alongside the result it reports the new carry, digit-carry and zero flags, each with its own update enable, and a skip request for the conditional instructions.

The file register address and a read strobe leave the block combinationally in the cycle the word arrives, so that the surrounding register file can return the operand in that same cycle. Every instruction that names a file register raises the read strobe, including those that only overwrite it. Program counter sequencing, subroutine linkage, interrupts and power management are left to other blocks. Jump-class words pass through with no effect.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_n` is low, every registered output (`out_valid`, `wr_data`, `f_waddr`, all write and flag enables, flag values and `skip`) is 0.
- R2: For a byte operation (bits 13:12 = 00), bit 7 = 0 sends the result to W only (`w_we`), and bit 7 = 1 sends it to the file register only (`f_we`). The file write address equals bits 6:0 of the word that produced it. `f_we` and `w_we` are never both high.
- R3: Add: byte code 0111 (bits 11:8) adds W and the file byte, and literal code 111x (bits 13:8 = 11111x) adds W and the literal in bits 7:0. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the 8-bit result is zero. All three flags are updated.
- R4: Subtract: byte code 0010 computes file minus W, and literal code 110x computes literal minus W. C and DC are 1 when no borrow leaves bit 7 or bit 3 respectively. Z is set on a zero result.
- R5: Logic: byte codes 0101 (AND), 0100 (OR) and 0110 (XOR) combine W with the file byte. Literal codes 1001 (AND), 1000 (OR) and 1010 (XOR) combine W with the literal. Only Z is updated.
- R6: Byte codes 1001 (complement), 1010 (increment), 0011 (decrement), 1000 (move) and 0001 (clear: bit 7 = 1 clears the file register, bit 7 = 0 clears W) update only Z. Code 0000 with bit 7 = 1 copies W to the file register and updates no flag.
- R7: Byte code 1101 rotates the file byte left through carry (the old C enters bit 0, bit 7 becomes C). Code 1100 rotates it right through carry (the old C enters bit 7, bit 0 becomes C). Only C is updated.
- R8: Byte code 1110 exchanges the two nibbles of the file byte and updates no flag.
- R9: Bit operations (bits 13:12 = 01) take the bit index from bits 9:7. Bits 11:10 = 00 clear and 01 set that bit of the file byte, which is written back to the file register with no flag update.
- R10: Skip: bits 11:10 = 10 skips when the indexed bit is 0, and 11 skips when it is 1; neither writes anything. Byte codes 1011 (decrement) and 1111 (increment) skip when their result is zero, follow the destination rule of R2, and update no flag.
- R11: `f_rd` is high combinationally, in the same cycle as a valid word, exactly for byte operations other than the two no-file forms of codes 0000 and 0001 (bit 7 = 0), and for all bit operations. `f_raddr` equals bits 6:0.
- R12: Literal codes 00xx and 01xx load the literal into W with no flag update. Words with bits 13:12 = 10, and the word 0x0000, write nothing, update no flag and do not skip.
- R13: Results appear on the registered outputs one cycle after `in_valid` is sampled high, with `out_valid` high. A cycle with `in_valid` low yields no write, flag update or skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word valid this cycle |
| instr | input | 14 | Instruction word |
| w_in | input | 8 | Current working register |
| f_rdata | input | 8 | Byte read from the addressed file register |
| c_in | input | 1 | Current carry flag |
| f_raddr | output | 7 | File read address (combinational) |
| f_rd | output | 1 | File read strobe (combinational) |
| out_valid | output | 1 | Registered result valid |
| wr_data | output | 8 | Result value |
| f_waddr | output | 7 | File write address |
| f_we | output | 1 | File register write enable |
| w_we | output | 1 | Working register write enable |
| c_out | output | 1 | New carry value |
| c_we | output | 1 | Carry update enable |
| dc_out | output | 1 | New digit-carry value |
| dc_we | output | 1 | Digit-carry update enable |
| z_out | output | 1 | New zero value |
| z_we | output | 1 | Zero update enable |
| skip | output | 1 | Skip-next-instruction request |

## Verification
The counting skips write their result and raise the skip request in the same output cycle. The bench provokes this by counting a file byte through zero (0x01 decremented, 0xFF incremented) with the destination bit set. It judges the written byte, the write target, the silent flags and the skip together on that one cycle. A second collision, the carry being consumed and produced by one rotate, is provoked with the incoming carry both set and clear. The bench then checks the rotated-in bit and the new carry in the same result cycle.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

   // instruction class, bits 13:12
   localparam logic [1:0] CLS_BYTE = 2'b00;
   localparam logic [1:0] CLS_BIT  = 2'b01;
   localparam logic [1:0] CLS_JUMP = 2'b10;
   localparam logic [1:0] CLS_LIT  = 2'b11;

   typedef enum logic [4:0] {
      OP_NONE,
      OP_PASS_A,
      OP_PASS_W,
      OP_ZERO,
      OP_ADD,
      OP_SUB,
      OP_AND,
      OP_IOR,
      OP_XOR,
      OP_COM,
      OP_INC,
      OP_DEC,
      OP_RL,
      OP_RR,
      OP_SWAP,
      OP_BCLR,
      OP_BSET
   } alu_op_e;

   typedef enum logic [1:0] {
      SK_NONE,
      SK_ZERO,
      SK_BIT_LO,
      SK_BIT_HI
   } skip_mode_e;

   typedef struct packed {
      alu_op_e    op;
      logic       use_lit;
      logic       wr_w;
      logic       wr_f;
      logic       upd_c;
      logic       upd_dc;
      logic       upd_z;
      skip_mode_e skip_mode;
      logic       rd_f;
   } exec_ctl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_exec_pkg::*;
#(
   parameter int INSTR_W = 14
) (
   input  logic [INSTR_W-1:0] instr,
   output exec_ctl_t          ctl
);

   logic [1:0] cls;
   logic [3:0] sub_op;
   logic       dst_f;

   assign cls    = instr[13:12];
   assign sub_op = instr[11:8];
   assign dst_f  = instr[7];

   always_comb begin
      ctl           = '0;
      ctl.op        = OP_NONE;
      ctl.skip_mode = SK_NONE;
      unique case (cls)
         CLS_BYTE: begin
            ctl.rd_f = 1'b1;
            ctl.wr_w = ~dst_f;
            ctl.wr_f = dst_f;
            unique case (sub_op)
               4'b0000: begin
                  if (dst_f) begin
                     ctl.op = OP_PASS_W;
                  end else begin
                     ctl.rd_f = 1'b0;
                     ctl.wr_w = 1'b0;
                  end
               end
               4'b0001: begin
                  ctl.op    = OP_ZERO;
                  ctl.upd_z = 1'b1;
                  ctl.rd_f  = dst_f;
               end
               4'b0010: begin
                  ctl.op     = OP_SUB;
                  ctl.upd_c  = 1'b1;
                  ctl.upd_dc = 1'b1;
                  ctl.upd_z  = 1'b1;
               end
               4'b0011: begin ctl.op = OP_DEC;    ctl.upd_z = 1'b1; end
               4'b0100: begin ctl.op = OP_IOR;    ctl.upd_z = 1'b1; end
               4'b0101: begin ctl.op = OP_AND;    ctl.upd_z = 1'b1; end
               4'b0110: begin ctl.op = OP_XOR;    ctl.upd_z = 1'b1; end
               4'b0111: begin
                  ctl.op     = OP_ADD;
                  ctl.upd_c  = 1'b1;
                  ctl.upd_dc = 1'b1;
                  ctl.upd_z  = 1'b1;
               end
               4'b1000: begin ctl.op = OP_PASS_A; ctl.upd_z = 1'b1; end
               4'b1001: begin ctl.op = OP_COM;    ctl.upd_z = 1'b1; end
               4'b1010: begin ctl.op = OP_INC;    ctl.upd_z = 1'b1; end
               4'b1011: begin ctl.op = OP_DEC;    ctl.skip_mode = SK_ZERO; end
               4'b1100: begin ctl.op = OP_RR;     ctl.upd_c = 1'b1; end
               4'b1101: begin ctl.op = OP_RL;     ctl.upd_c = 1'b1; end
               4'b1110: begin ctl.op = OP_SWAP; end
               default: begin ctl.op = OP_INC;    ctl.skip_mode = SK_ZERO; end
            endcase
         end
         CLS_BIT: begin
            ctl.rd_f = 1'b1;
            unique case (instr[11:10])
               2'b00:   begin ctl.op = OP_BCLR; ctl.wr_f = 1'b1; end
               2'b01:   begin ctl.op = OP_BSET; ctl.wr_f = 1'b1; end
               2'b10:   begin ctl.op = OP_PASS_A; ctl.skip_mode = SK_BIT_LO; end
               default: begin ctl.op = OP_PASS_A; ctl.skip_mode = SK_BIT_HI; end
            endcase
         end
         CLS_JUMP: begin
            ctl.op = OP_NONE;
         end
         default: begin
            ctl.use_lit = 1'b1;
            ctl.wr_w    = 1'b1;
            if (sub_op[3:2] != 2'b10) begin
               ctl.op = OP_PASS_A;
               if (sub_op[3]) begin
                  ctl.op     = sub_op[1] ? OP_ADD : OP_SUB;
                  ctl.upd_c  = 1'b1;
                  ctl.upd_dc = 1'b1;
                  ctl.upd_z  = 1'b1;
               end
            end else begin
               ctl.upd_z = 1'b1;
               unique case (sub_op[1:0])
                  2'b00:   ctl.op = OP_IOR;
                  2'b01:   ctl.op = OP_AND;
                  2'b10:   ctl.op = OP_XOR;
                  default: begin
                     ctl.op    = OP_NONE;
                     ctl.wr_w  = 1'b0;
                     ctl.upd_z = 1'b0;
                  end
               endcase
            end
         end
      endcase
   end

endmodule

// File: rtl/acc_addsub.sv
module acc_addsub #(
   parameter int DATA_W     = 8,
   parameter int RIPPLE_IMP = 0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              carry,
   output logic              half_carry
);

   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] b_eff;

   assign b_eff = sub ? ~b : b;

   generate
      if (RIPPLE_IMP != 0) begin : g_ripple
         logic [DATA_W:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
         end
         assign carry      = cy[DATA_W];
         assign half_carry = cy[HALF_W];
      end else begin : g_behav
         logic [DATA_W:0] full;
         logic [HALF_W:0] low;
         assign full = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
         assign low  = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                       + {{HALF_W{1'b0}}, sub};
         assign sum        = full[DATA_W-1:0];
         assign carry      = full[DATA_W];
         assign half_carry = low[HALF_W];
      end
   endgenerate

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_exec_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int BIDX_W     = 3,
   parameter int RIPPLE_IMP = 0
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] w_val,
   input  logic              c_in,
   input  logic [BIDX_W-1:0] bit_idx,
   output logic [DATA_W-1:0] result,
   output logic              c_res,
   output logic              dc_res,
   output logic              bit_val
);

   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] as_sum;
   logic              as_c;
   logic              as_dc;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         assign mask[i] = (bit_idx == BIDX_W'(i));
      end
   endgenerate

   assign bit_val = |(opa & mask);

   acc_addsub #(
      .DATA_W     (DATA_W),
      .RIPPLE_IMP (RIPPLE_IMP)
   ) u_addsub (
      .a          (opa),
      .b          (w_val),
      .sub        (op == OP_SUB),
      .sum        (as_sum),
      .carry      (as_c),
      .half_carry (as_dc)
   );

   always_comb begin
      result = opa;
      c_res  = as_c;
      dc_res = as_dc;
      unique case (op)
         OP_NONE:   result = opa;
         OP_PASS_A: result = opa;
         OP_PASS_W: result = w_val;
         OP_ZERO:   result = '0;
         OP_ADD:    result = as_sum;
         OP_SUB:    result = as_sum;
         OP_AND:    result = opa & w_val;
         OP_IOR:    result = opa | w_val;
         OP_XOR:    result = opa ^ w_val;
         OP_COM:    result = ~opa;
         OP_INC:    result = opa + DATA_W'(1);
         OP_DEC:    result = opa - DATA_W'(1);
         OP_RL: begin
            result = {opa[DATA_W-2:0], c_in};
            c_res  = opa[DATA_W-1];
         end
         OP_RR: begin
            result = {c_in, opa[DATA_W-1:1]};
            c_res  = opa[0];
         end
         OP_SWAP:   result = {opa[HALF_W-1:0], opa[DATA_W-1:HALF_W]};
         OP_BCLR:   result = opa & ~mask;
         default:   result = opa | mask;
      endcase
   end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
   import acc_exec_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 7,
   parameter int INSTR_W    = 14,
   parameter int RIPPLE_IMP = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  w_in,
   input  logic [DATA_W-1:0]  f_rdata,
   input  logic               c_in,
   output logic [ADDR_W-1:0]  f_raddr,
   output logic               f_rd,
   output logic               out_valid,
   output logic [DATA_W-1:0]  wr_data,
   output logic [ADDR_W-1:0]  f_waddr,
   output logic               f_we,
   output logic               w_we,
   output logic               c_out,
   output logic               c_we,
   output logic               dc_out,
   output logic               dc_we,
   output logic               z_out,
   output logic               z_we,
   output logic               skip
);

   localparam int BIDX_W = $clog2(DATA_W);
   localparam int LIT_W  = DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("acc_exec_unit: encoding fixes the datapath at 8 bits");
      end
      if (ADDR_W != 7) begin : g_bad_addr
         $error("acc_exec_unit: encoding fixes the file address at 7 bits");
      end
      if (INSTR_W != 14) begin : g_bad_instr
         $error("acc_exec_unit: encoding fixes the word at 14 bits");
      end
      if (ADDR_W + BIDX_W > INSTR_W - 4) begin : g_bad_fields
         $error("acc_exec_unit: bit and address fields overlap the opcode");
      end
   endgenerate

   exec_ctl_t         ctl;
   logic [DATA_W-1:0] opa;
   logic [DATA_W-1:0] res;
   logic              c_res;
   logic              dc_res;
   logic              bit_val;
   logic              skip_nx;
   logic [BIDX_W-1:0] bit_idx;

   acc_decode #(
      .INSTR_W (INSTR_W)
   ) u_decode (
      .instr (instr),
      .ctl   (ctl)
   );

   assign bit_idx = instr[ADDR_W +: BIDX_W];
   assign opa     = ctl.use_lit ? instr[LIT_W-1:0] : f_rdata;

   acc_alu #(
      .DATA_W     (DATA_W),
      .BIDX_W     (BIDX_W),
      .RIPPLE_IMP (RIPPLE_IMP)
   ) u_alu (
      .op      (ctl.op),
      .opa     (opa),
      .w_val   (w_in),
      .c_in    (c_in),
      .bit_idx (bit_idx),
      .result  (res),
      .c_res   (c_res),
      .dc_res  (dc_res),
      .bit_val (bit_val)
   );

   always_comb begin
      unique case (ctl.skip_mode)
         SK_ZERO:   skip_nx = (res == '0);
         SK_BIT_LO: skip_nx = ~bit_val;
         SK_BIT_HI: skip_nx = bit_val;
         default:   skip_nx = 1'b0;
      endcase
   end

   assign f_raddr = instr[ADDR_W-1:0];
   assign f_rd    = in_valid & ctl.rd_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wr_data   <= '0;
         f_waddr   <= '0;
         f_we      <= 1'b0;
         w_we      <= 1'b0;
         c_out     <= 1'b0;
         c_we      <= 1'b0;
         dc_out    <= 1'b0;
         dc_we     <= 1'b0;
         z_out     <= 1'b0;
         z_we      <= 1'b0;
         skip      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         wr_data   <= res;
         f_waddr   <= instr[ADDR_W-1:0];
         f_we      <= in_valid & ctl.wr_f;
         w_we      <= in_valid & ctl.wr_w;
         c_out     <= c_res;
         c_we      <= in_valid & ctl.upd_c;
         dc_out    <= dc_res;
         dc_we     <= in_valid & ctl.upd_dc;
         z_out     <= (res == '0);
         z_we      <= in_valid & ctl.upd_z;
         skip      <= in_valid & skip_nx;
      end
   end

endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] f_raddr,
   input logic              f_rd,
   input logic              out_valid,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] f_waddr,
   input logic              f_we,
   input logic              w_we,
   input logic              c_we,
   input logic              dc_we,
   input logic              z_out,
   input logic              z_we,
   input logic              skip
);

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && !f_we && !w_we && !c_we && !dc_we && !z_we && !skip)); // R1

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !(f_we && w_we)); // R2

   AST_WADDR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      f_we |-> (f_waddr == $past(f_raddr))); // R2

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (z_we && (f_we || w_we)) |-> (z_out == (wr_data == '0))); // R5

   AST_DC_WITH_C: assert property (@(posedge clk) disable iff (!rst_n)
      dc_we |-> (c_we && z_we)); // R3

   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> (!c_we && !dc_we && !z_we)); // R10

   AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      f_we |-> $past(f_rd)); // R11

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !f_we && !w_we && !c_we && !z_we && !skip)); // R13

endmodule

bind acc_exec_unit acc_exec_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_exec_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .f_raddr   (f_raddr),
   .f_rd      (f_rd),
   .out_valid (out_valid),
   .wr_data   (wr_data),
   .f_waddr   (f_waddr),
   .f_we      (f_we),
   .w_we      (w_we),
   .c_we      (c_we),
   .dc_we     (dc_we),
   .z_out     (z_out),
   .z_we      (z_we),
   .skip      (skip)
);

// File: tb/acc_exec_unit_tb_top.sv
module acc_exec_unit_tb_top;

   logic        clk;
   logic        rst_n;
   logic        in_valid;
   logic [13:0] instr;
   logic [7:0]  w_in;
   logic [7:0]  f_rdata;
   logic        c_in;
   logic [6:0]  f_raddr;
   logic        f_rd;
   logic        out_valid;
   logic [7:0]  wr_data;
   logic [6:0]  f_waddr;
   logic        f_we;
   logic        w_we;
   logic        c_out;
   logic        c_we;
   logic        dc_out;
   logic        dc_we;
   logic        z_out;
   logic        z_we;
   logic        skip;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   acc_exec_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .instr     (instr),
      .w_in      (w_in),
      .f_rdata   (f_rdata),
      .c_in      (c_in),
      .f_raddr   (f_raddr),
      .f_rd      (f_rd),
      .out_valid (out_valid),
      .wr_data   (wr_data),
      .f_waddr   (f_waddr),
      .f_we      (f_we),
      .w_we      (w_we),
      .c_out     (c_out),
      .c_we      (c_we),
      .dc_out    (dc_out),
      .dc_we     (dc_we),
      .z_out     (z_out),
      .z_we      (z_we),
      .skip      (skip)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   typedef struct packed {
      logic [23:0] tag;
      logic [13:0] ins;
      logic [7:0]  w;
      logic [7:0]  f;
      logic        ci;
      logic        rd;
      logic [7:0]  data;
      logic        fwe;
      logic        wwe;
      logic        cwe;
      logic        c;
      logic        dcwe;
      logic        dc;
      logic        zwe;
      logic        z;
      logic        sk;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t VEC [NV] = '{
      '{"R3 ", 14'h07A5, 8'h38, 8'h4C, 1'b0, 1'b1, 8'h84, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
      '{"R3 ", 14'h3EC8, 8'h38, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      '{"R3 ", 14'h0725, 8'h0F, 8'h01, 1'b0, 1'b1, 8'h10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
      '{"R4 ", 14'h0225, 8'h23, 8'h50, 1'b0, 1'b1, 8'h2D, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{"R4 ", 14'h3C10, 8'h20, 8'h00, 1'b0, 1'b0, 8'hF0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
      '{"R4 ", 14'h02A5, 8'h42, 8'h42, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      '{"R4 ", 14'h3C00, 8'h01, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      '{"R5 ", 14'h0525, 8'hF0, 8'h0F, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{"R5 ", 14'h3881, 8'h12, 8'h00, 1'b0, 1'b0, 8'h93, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{"R5 ", 14'h06A5, 8'hAA, 8'hA5, 1'b0, 1'b1, 8'h0F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{"R5 ", 14'h393C, 8'hC3, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{"R5 ", 14'h3A5A, 8'h5A, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{"R6 ", 14'h09A5, 8'h00, 8'hFF, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{"R6 ", 14'h0A25, 8'h00, 8'hFF, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{"R6 ", 14'h03A5, 8'h00, 8'h01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{"R6 ", 14'h0825, 8'h00, 8'h7E, 1'b0, 1'b1, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      '{"R11", 14'h01A5, 8'h00, 8'h99, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{"R6 ", 14'h0100, 8'h77, 8'h99, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{"R11", 14'h00A5, 8'h3C, 8'h11, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R7 ", 14'h0DA5, 8'h00, 8'h81, 1'b0, 1'b1, 8'h02, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R7 ", 14'h0C25, 8'h00, 8'h02, 1'b1, 1'b1, 8'h81, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R7 ", 14'h0D25, 8'h00, 8'h7F, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R8 ", 14'h0EA5, 8'h00, 8'h3C, 1'b0, 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R9 ", 14'h16A5, 8'h00, 8'h00, 1'b0, 1'b1, 8'h20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R9 ", 14'h13A5, 8'h00, 8'hFF, 1'b0, 1'b1, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R10", 14'h1825, 8'h00, 8'hFE, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{"R10", 14'h1DA5, 8'h00, 8'h08, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{"R10", 14'h1DA5, 8'h00, 8'hF7, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R10", 14'h0BA5, 8'h00, 8'h01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{"R10", 14'h0F25, 8'h00, 8'h10, 1'b0, 1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R10", 14'h0FA5, 8'h00, 8'hFF, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{"R12", 14'h30A7, 8'h00, 8'h00, 1'b0, 1'b0, 8'hA7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R12", 14'h3400, 8'h5A, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R12", 14'h2923, 8'h5A, 8'h66, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R12", 14'h0000, 8'h5A, 8'h66, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{"R2 ", 14'h08A5, 8'h33, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
   };

   function automatic bit out_matches(vec_t v);
      bit ok = 1'b1;
      if (out_valid !== 1'b1) ok = 1'b0;
      if ({f_we, w_we, c_we, dc_we, z_we, skip} !== {v.fwe, v.wwe, v.cwe, v.dcwe, v.zwe, v.sk}) ok = 1'b0;
      if ((v.fwe || v.wwe) && wr_data !== v.data) ok = 1'b0;
      if (v.fwe && f_waddr !== v.ins[6:0]) ok = 1'b0;
      if (v.cwe && c_out !== v.c) ok = 1'b0;
      if (v.dcwe && dc_out !== v.dc) ok = 1'b0;
      if (v.zwe && z_out !== v.z) ok = 1'b0;
      return ok;
   endfunction

   task automatic drive(input logic [13:0] ins, input logic [7:0] w, input logic [7:0] f, input logic ci);
      in_valid = 1'b1;
      instr    = ins;
      w_in     = w;
      f_rdata  = f;
      c_in     = ci;
   endtask

   initial begin
      in_valid = 1'b0;
      instr    = '0;
      w_in     = '0;
      f_rdata  = '0;
      c_in     = 1'b0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state, with a valid word pending at the inputs
      drive(14'h07A5, 8'h11, 8'h22, 1'b1);
      @(negedge clk);
      n_checks++;
      if ({out_valid, wr_data, f_waddr, f_we, w_we, c_out, c_we, dc_out, dc_we, z_out, z_we, skip} !== '0) begin
         n_fails++;
         $display("FAIL R1 reset outputs: actual %b expected all zero",
                  {out_valid, wr_data, f_waddr, f_we, w_we, c_out, c_we, dc_out, dc_we, z_out, z_we, skip});
      end
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].ins, VEC[i].w, VEC[i].f, VEC[i].ci);
         #1;
         n_checks++;
         if (f_rd !== VEC[i].rd || (VEC[i].rd && f_raddr !== VEC[i].ins[6:0])) begin
            n_fails++;
            $display("FAIL R11 vec %0d (%s) read strobe/addr: actual %b/%h expected %b/%h",
                     i, VEC[i].tag, f_rd, f_raddr, VEC[i].rd, VEC[i].ins[6:0]);
         end
         @(negedge clk);
         n_checks++;
         if (!out_matches(VEC[i])) begin
            n_fails++;
            $display("FAIL %s vec %0d: actual v=%b d=%h a=%h fwe=%b wwe=%b c=%b/%b dc=%b/%b z=%b/%b sk=%b expected d=%h fwe=%b wwe=%b c=%b/%b dc=%b/%b z=%b/%b sk=%b",
                     VEC[i].tag, i, out_valid, wr_data, f_waddr, f_we, w_we, c_we, c_out, dc_we, dc_out,
                     z_we, z_out, skip, VEC[i].data, VEC[i].fwe, VEC[i].wwe, VEC[i].cwe, VEC[i].c,
                     VEC[i].dcwe, VEC[i].dc, VEC[i].zwe, VEC[i].z, VEC[i].sk);
         end
         in_valid = 1'b0;
      end

      // R13: latency and idle behaviour
      @(negedge clk);
      drive(14'h0FA5, 8'h00, 8'hFF, 1'b0);
      #1;
      n_checks++;
      if (out_valid !== 1'b0 || skip !== 1'b0 || f_we !== 1'b0) begin
         n_fails++;
         $display("FAIL R13 result before edge: actual v=%b sk=%b fwe=%b expected 0 0 0", out_valid, skip, f_we);
      end
      @(negedge clk);
      in_valid = 1'b0;
      n_checks++;
      if (out_valid !== 1'b1 || skip !== 1'b1 || f_we !== 1'b1) begin
         n_fails++;
         $display("FAIL R13 result after edge: actual v=%b sk=%b fwe=%b expected 1 1 1", out_valid, skip, f_we);
      end
      @(negedge clk);
      n_checks++;
      if ({out_valid, f_we, w_we, c_we, dc_we, z_we, skip} !== 7'b0) begin
         n_fails++;
         $display("FAIL R13 idle cycle: actual %b expected 0000000", {out_valid, f_we, w_we, c_we, dc_we, z_we, skip});
      end
      #1;
      n_checks++;
      if (f_rd !== 1'b0) begin
         n_fails++;
         $display("FAIL R11 strobe with in_valid low: actual %b expected 0", f_rd);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule